// File: doc/BRIEF.md
# Speculative Return Address Stack

This block holds predicted return addresses for a fetch-stage branch predictor. Each hardware thread has its own circular stack. A thread id picks the stack that the operation inputs act on, and the same id picks the stack shown on the read outputs. A predicted call pushes the address of the call instruction. A predicted return reads the top value and the top index, and the predictor keeps both as a checkpoint before it pops.

When a return was predicted on a wrong path, the predictor undoes it with the repair inputs. A repair writes a saved index back into the top pointer and a saved address back into that slot. The depth is a parameter from 2 to 16, so a saved index always fits in four bits. The empty flag lets the predictor turn a return prediction into not-taken when there is no address to return to. When the stack is full, a push overwrites the oldest entry. A pop on an empty stack does nothing.

Top module: `ras_stack`

## Requirements
- R1: After reset, every thread reads empty, with top index 0 and top value 0.
- R2: A push with no pop and no repair in the same cycle acts on the selected thread. From the next cycle, the top index is the old index plus one, wrapping from DEPTH-1 to 0. The top value is the pushed address, and empty is low.
- R3: A pop on a non-empty thread, with no repair in the same cycle, moves the top index down by one, wrapping from 0 to DEPTH-1. The top value becomes the entry stored in that slot, and the entry count drops by one.
- R4: A pop on an empty thread, with no repair in the same cycle, leaves that thread's top index unchanged, and the thread stays empty.
- R5: The entry count saturates at DEPTH, so a push onto a full stack overwrites the oldest entry. After N pushes with N > DEPTH, DEPTH pops return the last DEPTH addresses, newest first, and the thread then reads empty.
- R6: A repair sets the selected thread's top index to the repair index and writes the repair value into that slot. The entry count rises by one, saturating at DEPTH, so empty is low on the next cycle.
- R7: When repair, pop and push are asserted in the same cycle, only one acts. Repair has the highest priority, pop comes next, and push is lowest.
- R8: An operation on one thread leaves the top index, top value and empty flag of every other thread unchanged.
- R9: The read outputs show the state of the thread selected by `tid` in the same cycle that `tid` changes, with no register on the read path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tid | input | TW | Thread that the operations act on and that the read outputs show |
| push_en | input | 1 | Push `push_addr` (predicted call) |
| push_addr | input | AW | Address of the call instruction |
| pop_en | input | 1 | Pop (predicted return) |
| fix_en | input | 1 | Repair: restore a checkpointed top |
| fix_idx | input | IW | Checkpointed top index |
| fix_val | input | AW | Checkpointed top value |
| top_val | output | AW | Top entry of the selected thread |
| top_idx | output | IW | Top index of the selected thread |
| empty | output | 1 | Selected thread holds no entries |

## Verification
Whenever the thread id is held across the edge, the assertions check every cycle that a push advances the index and shows the pushed address. They also check that a non-empty pop steps the index back, that an empty pop leaves it alone, and that a repair lands its index and value even when a push or pop is asserted with it. Overwriting the oldest entry on a full stack, draining back to empty after a wrap, and leaving the other threads untouched all depend on history that no single-cycle property covers. Only the bench's scenarios show those, by comparing every thread against an arithmetic model after each step.

// File: rtl/ras_pkg.sv
package ras_pkg;

   localparam int RAS_MAX_DEPTH = 16;

   typedef enum logic [1:0] {
      RAS_IDLE = 2'd0,
      RAS_PUSH = 2'd1,
      RAS_POP  = 2'd2,
      RAS_FIX  = 2'd3
   } ras_op_e;

   // Fixed priority: repair, then pop, then push.
   function automatic ras_op_e pick_op(input logic push, input logic pop,
                                       input logic fix);
      if (fix)
         return RAS_FIX;
      else if (pop)
         return RAS_POP;
      else if (push)
         return RAS_PUSH;
      else
         return RAS_IDLE;
   endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
   parameter int DEPTH = 8,
   parameter int IW    = 3,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          push_en,
   input  logic          pop_en,
   input  logic          fix_en,
   input  logic [IW-1:0] fix_idx,
   output logic [IW-1:0] tos,
   output logic [CW-1:0] cnt,
   output logic          wr_en,
   output logic          wr_fix,
   output logic [IW-1:0] wr_idx
);
   import ras_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   ras_op_e       op;
   logic [IW-1:0] tos_inc, tos_dec, tos_nx;
   logic [CW-1:0] cnt_sat, cnt_nx;

   assign op      = sel ? pick_op(push_en, pop_en, fix_en) : RAS_IDLE;
   assign tos_inc = (tos == LAST) ? '0 : tos + 1'b1;
   assign tos_dec = (tos == '0) ? LAST : tos - 1'b1;
   assign cnt_sat = (cnt == FULL) ? cnt : cnt + 1'b1;

   always_comb begin
      tos_nx = tos;
      cnt_nx = cnt;
      wr_en  = 1'b0;
      wr_fix = 1'b0;
      wr_idx = tos_inc;
      unique case (op)
         RAS_FIX: begin
            tos_nx = fix_idx;
            cnt_nx = cnt_sat;
            wr_en  = 1'b1;
            wr_fix = 1'b1;
            wr_idx = fix_idx;
         end
         RAS_POP: begin
            if (cnt != '0) begin
               tos_nx = tos_dec;
               cnt_nx = cnt - 1'b1;
            end
         end
         RAS_PUSH: begin
            tos_nx = tos_inc;
            cnt_nx = cnt_sat;
            wr_en  = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tos <= '0;
         cnt <= '0;
      end else begin
         tos <= tos_nx;
         cnt <= cnt_nx;
      end
   end

endmodule

// File: rtl/ras_bank.sv
module ras_bank #(
   parameter int DEPTH = 8,
   parameter int IW    = 3,
   parameter int AW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_data
);
   logic [AW-1:0] slot [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[s] <= '0;
         else if (wr_en && (wr_idx == IW'(s)))
            slot[s] <= wr_data;
      end
   end

   assign rd_data = slot[rd_idx];

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
   parameter int THREADS = 2,
   parameter int DEPTH   = 8,
   parameter int AW      = 32,
   localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW     = $clog2(DEPTH + 1),
   localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tid,
   input  logic          push_en,
   input  logic [AW-1:0] push_addr,
   input  logic          pop_en,
   input  logic          fix_en,
   input  logic [IW-1:0] fix_idx,
   input  logic [AW-1:0] fix_val,
   output logic [AW-1:0] top_val,
   output logic [IW-1:0] top_idx,
   output logic          empty
);
   if (DEPTH < 2 || DEPTH > ras_pkg::RAS_MAX_DEPTH) begin : g_bad_depth
      $error("ras_stack: DEPTH must lie in 2..16 so a saved index fits 4 bits");
   end
   if (THREADS < 1) begin : g_bad_threads
      $error("ras_stack: THREADS must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("ras_stack: AW must be at least 1");
   end

   logic [IW-1:0] th_tos [THREADS];
   logic [CW-1:0] th_cnt [THREADS];
   logic [AW-1:0] th_top [THREADS];

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic          sel;
      logic          wr_en, wr_fix;
      logic [IW-1:0] wr_idx;
      logic [AW-1:0] wr_data;

      assign sel     = (tid == TW'(t));
      assign wr_data = wr_fix ? fix_val : push_addr;

      ras_ptr #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ptr (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (sel),
         .push_en (push_en),
         .pop_en  (pop_en),
         .fix_en  (fix_en),
         .fix_idx (fix_idx),
         .tos     (th_tos[t]),
         .cnt     (th_cnt[t]),
         .wr_en   (wr_en),
         .wr_fix  (wr_fix),
         .wr_idx  (wr_idx)
      );

      ras_bank #(.DEPTH(DEPTH), .IW(IW), .AW(AW)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_idx  (wr_idx),
         .wr_data (wr_data),
         .rd_idx  (th_tos[t]),
         .rd_data (th_top[t])
      );
   end

   if (THREADS == 1) begin : g_one
      assign top_val = th_top[0];
      assign top_idx = th_tos[0];
      assign empty   = (th_cnt[0] == '0);
   end else begin : g_many
      always_comb begin
         top_val = '0;
         top_idx = '0;
         empty   = 1'b1;
         for (int t = 0; t < THREADS; t++) begin
            if (tid == TW'(t)) begin
               top_val = th_top[t];
               top_idx = th_tos[t];
               empty   = (th_cnt[t] == '0);
            end
         end
      end
   end

endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
   parameter int THREADS = 2,
   parameter int DEPTH   = 8,
   parameter int AW      = 32,
   parameter int IW      = 3,
   parameter int TW      = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [TW-1:0] tid,
   input logic          push_en,
   input logic [AW-1:0] push_addr,
   input logic          pop_en,
   input logic          fix_en,
   input logic [IW-1:0] fix_idx,
   input logic [AW-1:0] fix_val,
   input logic [AW-1:0] top_val,
   input logic [IW-1:0] top_idx,
   input logic          empty
);
   logic [IW-1:0] idx_up, idx_dn;
   logic          armed;

   assign idx_up = (top_idx == IW'(DEPTH - 1)) ? '0 : top_idx + 1'b1;
   assign idx_dn = (top_idx == '0) ? IW'(DEPTH - 1) : top_idx - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2
   a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && push_en && !pop_en && !fix_en) |=>
      (tid != $past(tid)) ||
      (top_idx == $past(idx_up) && top_val == $past(push_addr) && !empty));

   // R3
   a_r3_pop_steps_back: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pop_en && !fix_en && !empty) |=>
      (tid != $past(tid)) || (top_idx == $past(idx_dn)));

   // R4
   a_r4_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pop_en && !fix_en && empty) |=>
      (tid != $past(tid)) || (top_idx == $past(top_idx) && empty));

   // R6, R7: repair wins over any push or pop in the same cycle
   a_r6_fix_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && fix_en) |=>
      (tid != $past(tid)) ||
      (top_idx == $past(fix_idx) && top_val == $past(fix_val) && !empty));

   // R7: a pop alongside a push on a non-empty stack never advances
   a_r7_pop_over_push: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pop_en && push_en && !fix_en && !empty) |=>
      (tid != $past(tid)) || (top_idx != $past(idx_up)) || (DEPTH == 2));

endmodule

bind ras_stack ras_stack_chk #(
   .THREADS (THREADS),
   .DEPTH   (DEPTH),
   .AW      (AW),
   .IW      (IW),
   .TW      (TW)
) u_ras_stack_chk (.*);

// File: tb/ras_stack_bench.sv
`timescale 1ns/1ps
module ras_stack_bench;
   localparam int TH = 2;
   localparam int D  = 4;
   localparam int AW = 16;
   localparam int IW = 2;
   localparam int TW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] tid = '0;
   logic          push_en = 1'b0, pop_en = 1'b0, fix_en = 1'b0;
   logic [AW-1:0] push_addr = '0, fix_val = '0;
   logic [IW-1:0] fix_idx = '0;
   logic [AW-1:0] top_val;
   logic [IW-1:0] top_idx;
   logic          empty;

   int n_chk = 0;
   int n_bad = 0;

   int            m_tos [TH];
   int            m_cnt [TH];
   logic [AW-1:0] m_mem [TH][D];
   logic [15:0]   lfsr = 16'hACE1;

   always #2 clk = ~clk;

   ras_stack #(.THREADS(TH), .DEPTH(D), .AW(AW)) u_ras_stack (
      .clk(clk), .rst_n(rst_n), .tid(tid),
      .push_en(push_en), .push_addr(push_addr), .pop_en(pop_en),
      .fix_en(fix_en), .fix_idx(fix_idx), .fix_val(fix_val),
      .top_val(top_val), .top_idx(top_idx), .empty(empty));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Compare every thread against the model; tag names the requirement.
   task automatic check_all(input string tag);
      for (int t = 0; t < TH; t++) begin
         @(negedge clk);
         tid = TW'(t);
         #1;
         check(top_idx == IW'(m_tos[t]), {tag, " idx"}, int'(top_idx), m_tos[t]);
         check(empty == (m_cnt[t] == 0), {tag, " empty"}, int'(empty), int'(m_cnt[t] == 0));
         check(top_val == m_mem[t][m_tos[t]], {tag, " val"}, int'(top_val),
               int'(m_mem[t][m_tos[t]]));
      end
   endtask

   task automatic model(input int t, input bit pu, input bit po, input bit fx,
                        input logic [AW-1:0] a, input int fi, input logic [AW-1:0] fv);
      if (fx) begin
         m_tos[t] = fi;
         m_mem[t][fi] = fv;
         if (m_cnt[t] < D) m_cnt[t]++;
      end else if (po) begin
         if (m_cnt[t] > 0) begin
            m_tos[t] = (m_tos[t] + D - 1) % D;
            m_cnt[t]--;
         end
      end else if (pu) begin
         m_tos[t] = (m_tos[t] + 1) % D;
         m_mem[t][m_tos[t]] = a;
         if (m_cnt[t] < D) m_cnt[t]++;
      end
   endtask

   task automatic op(input int t, input bit pu, input bit po, input bit fx,
                     input logic [AW-1:0] a, input int fi, input logic [AW-1:0] fv);
      @(negedge clk);
      tid = TW'(t); push_en = pu; pop_en = po; fix_en = fx;
      push_addr = a; fix_idx = IW'(fi); fix_val = fv;
      @(posedge clk);
      #1;
      push_en = 1'b0; pop_en = 1'b0; fix_en = 1'b0;
      model(t, pu, po, fx, a, fi, fv);
   endtask

   initial begin
      for (int t = 0; t < TH; t++) begin
         m_tos[t] = 0; m_cnt[t] = 0;
         for (int s = 0; s < D; s++) m_mem[t][s] = '0;
      end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");

      // R2 and R5: wrap past depth on thread 0, check thread 1 untouched (R8)
      for (int i = 0; i < D + 2; i++) begin
         op(0, 1, 0, 0, AW'(16'h1000 + i), 0, '0);
         check_all("R2 R8 push");
      end
      // R5: drain returns last D addresses newest first, then empty
      for (int i = 0; i < D; i++) begin
         @(negedge clk); tid = '0; #1;
         check(top_val == AW'(16'h1000 + D + 1 - i), "R5 drain order",
               int'(top_val), 16'h1000 + D + 1 - i);
         op(0, 0, 1, 0, '0, 0, '0);
         check_all("R3 pop");
      end
      @(negedge clk); tid = '0; #1;
      check(empty == 1'b1, "R5 drained empty", int'(empty), 1);
      // R4: extra pops on empty
      op(0, 0, 1, 0, '0, 0, '0);
      check_all("R4 empty pop");
      op(1, 0, 1, 0, '0, 0, '0);
      check_all("R4 empty pop t1");

      // R6: repair on an empty thread and a populated one
      op(1, 0, 0, 1, '0, 3, 16'hBEEF);
      check_all("R6 repair");
      op(1, 1, 0, 0, 16'h2222, 0, '0);
      op(1, 0, 1, 0, '0, 0, '0);
      op(1, 0, 0, 1, '0, 1, 16'h3333);
      check_all("R6 repair populated");

      // R7: every combination of the three requests on each thread
      for (int t = 0; t < TH; t++)
         for (int c = 0; c < 8; c++) begin
            op(t, c[0], c[1], c[2], AW'(16'h4000 + c), (c + t) % D, AW'(16'h5000 + c));
            check_all("R7 priority");
         end

      // R9: read path follows tid in the same cycle (checked at +1ns inside check_all)
      check_all("R9 read mux");

      // Near-exhaustive pseudo-random sweep over both threads
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         op(int'(lfsr[0]), lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5] & lfsr[6],
            lfsr, int'(lfsr[9:8]) % D, ~lfsr);
         check_all("R2 R3 R6 R8 sweep");
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule